// File: doc/BRIEF.md
# I/Q Proportional-Integral Field Controller with Table Feedforward

This block closes a digital RF field loop on the in-phase and quadrature parts of a cavity signal. On every sample it reads a setpoint pair and a feedforward pair from two time-indexed tables. A trigger restarts the sample index, which then steps once per clock and stops on the final entry. For each component, the measured value is subtracted from the setpoint. The resulting error drives a proportional term scaled by KP/2^7 and an integral term scaled by KI/2^18. The integral term comes from a 40-bit saturating accumulator.

The feedforward pair passes through a programmable delay of 0 to 63 samples and is added to the controller output. The sum is clipped symmetrically to a programmable limit and leaves as a 16-bit signed word for each DAC channel. An RF-off input forces the drive to zero and empties the integrator. Both tables are loaded through a single synchronous write port.

Top module: `iq_pi_ctrl`

## Requirements
- R1: After reset both drive outputs are 0, the accumulators are 0, and the sample index rests on the last table entry (2^TAB_AW-1), so entries are read from there until a trigger arrives.
- R2: A trigger moves the index to entry 0 on that clock edge. The index then advances by one on each clock and holds at the last entry.
- R3: A write with wr_sel=0 stores {wr_i, wr_q} into setpoint entry wr_addr, and a write with wr_sel=1 stores it into feedforward entry wr_addr. A read of the same entry in the same cycle returns the old content.
- R4: The error is setpoint minus measured, 17-bit signed. The proportional term is floor(error*KP/2^7), with KP unsigned.
- R5: The accumulator adds error*KI (KI unsigned) on every sample. The integral term is floor(updated accumulator/2^18).
- R6: The accumulator saturates at -2^39 and 2^39-1 instead of wrapping.
- R7: The feedforward value added is the table value read ff_dly samples earlier (ff_dly 0 to 63). A delay of 0 adds the value read with the current setpoint.
- R8: Each drive is the sum of the three terms clamped independently to the range [-limit, +limit].
- R9: While rf_off is high, the drive on the following cycle is 0 and the accumulator is cleared.
- R10: A measured value sampled at clock edge k, and the table entry indexed at edge k, appear in the drive after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Restart table index at entry 0 |
| rf_off | input | 1 | Force zero drive and clear integrator |
| meas_i | input | 16 | Measured in-phase value, signed |
| meas_q | input | 16 | Measured quadrature value, signed |
| kp | input | 16 | Proportional gain register, unsigned |
| ki | input | 16 | Integral gain register, unsigned |
| limit | input | 15 | Clamp magnitude, unsigned |
| ff_dly | input | 6 | Feedforward delay in samples |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 selects setpoint table, 1 selects feedforward table |
| wr_addr | input | TAB_AW | Table entry to write |
| wr_i | input | 16 | In-phase word to write |
| wr_q | input | 16 | Quadrature word to write |
| drive_i | output | 16 | In-phase DAC drive, signed |
| drive_q | output | 16 | Quadrature DAC drive, signed |

## Verification
The hardest state to reach from the ports is accumulator saturation. The 40-bit sum is hidden behind the 2^18 shift and the output clamp, so the clamped drive looks the same whether the accumulator has saturated or not. The bench parks the index on one entry and applies the largest error with the largest KI for about 300 samples, which drives the accumulator into its top rail. It then reverses the error. The drive must stay pinned at +limit for exactly the number of samples that a saturated accumulator needs to unwind. A wrapped accumulator would flip to -limit at once, and an unsaturated one would unwind over a different number of samples. An arithmetic model in the bench predicts the drive cycle by cycle through every sweep.

// File: rtl/iq_pi_ctrl.sv
module iq_pi_ctrl #(
  parameter int DW     = 16,
  parameter int TAB_AW = 10,
  parameter int ACC_W  = 40,
  parameter int GW     = 16,
  parameter int DLY_W  = 6,
  parameter int KP_SH  = 7,
  parameter int KI_SH  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              rf_off,
  input  logic [DW-1:0]     meas_i,
  input  logic [DW-1:0]     meas_q,
  input  logic [GW-1:0]     kp,
  input  logic [GW-1:0]     ki,
  input  logic [DW-2:0]     limit,
  input  logic [DLY_W-1:0]  ff_dly,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [TAB_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_i,
  input  logic [DW-1:0]     wr_q,
  output logic [DW-1:0]     drive_i,
  output logic [DW-1:0]     drive_q
);
  localparam int DEPTH = 1 << TAB_AW;
  localparam int NDLY  = (1 << DLY_W) - 1;
  localparam int EW    = DW + 1;
  localparam int PW    = EW + GW + 1;
  localparam int AW1   = ACC_W + 1;
  localparam int SW    = ACC_W + 2;
  localparam logic [TAB_AW-1:0] LAST = '1;

  logic [TAB_AW-1:0] idx;
  logic [2*DW-1:0]   sp_mem [DEPTH];
  logic [2*DW-1:0]   ff_mem [DEPTH];
  logic [2*DW-1:0]   sp_rd, ff_rd, ms_rd, ff_sel;
  logic [2*DW-1:0]   ff_sr [NDLY];

  always_ff @(posedge clk) begin
    if (rst)                idx <= LAST;
    else if (trig)          idx <= '0;
    else if (idx != LAST)   idx <= idx + TAB_AW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_sel) sp_mem[wr_addr] <= {wr_i, wr_q};
    if (wr_en &&  wr_sel) ff_mem[wr_addr] <= {wr_i, wr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_rd <= '0;
      ff_rd <= '0;
      ms_rd <= '0;
      for (int k = 0; k < NDLY; k++) ff_sr[k] <= '0;
    end else begin
      sp_rd <= sp_mem[idx];
      ff_rd <= ff_mem[idx];
      ms_rd <= {meas_i, meas_q};
      ff_sr[0] <= ff_rd;
      for (int k = 1; k < NDLY; k++) ff_sr[k] <= ff_sr[k-1];
    end
  end

  assign ff_sel = (ff_dly == '0) ? ff_rd : ff_sr[ff_dly - DLY_W'(1)];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [DW-1:0]    sp, ms, ffv, drv;
    logic signed [EW-1:0]    err;
    logic signed [PW-1:0]    pprod, iprod;
    logic signed [AW1-1:0]   asum;
    logic signed [ACC_W-1:0] acc, acc_nx;
    logic signed [SW-1:0]    tot, lim, clip;

    assign sp  = sp_rd[(2-c)*DW-1 -: DW];
    assign ms  = ms_rd[(2-c)*DW-1 -: DW];
    assign ffv = ff_sel[(2-c)*DW-1 -: DW];
    assign err   = EW'(sp) - EW'(ms);
    assign pprod = PW'(err) * PW'($signed({1'b0, kp}));
    assign iprod = PW'(err) * PW'($signed({1'b0, ki}));
    assign asum  = AW1'(acc) + AW1'(iprod);
    assign acc_nx = (asum[ACC_W] != asum[ACC_W-1])
                  ? (asum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}})
                  : asum[ACC_W-1:0];
    assign tot  = SW'(pprod >>> KP_SH) + SW'(acc_nx >>> KI_SH) + SW'(ffv);
    assign lim  = SW'($signed({1'b0, limit}));
    assign clip = (tot > lim) ? lim : (tot < -lim) ? -lim : tot;

    always_ff @(posedge clk) begin
      if (rst || rf_off) begin
        acc <= '0;
        drv <= '0;
      end else begin
        acc <= acc_nx;
        drv <= clip[DW-1:0];
      end
    end
  end

  assign drive_i = g_ch[0].drv;
  assign drive_q = g_ch[1].drv;

  assert_rfoff_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rf_off |=> (drive_i == '0 && drive_q == '0));
  assert_rfoff_acc_R9: assert property (@(posedge clk) disable iff (rst)
    rf_off |=> (g_ch[0].acc == '0 && g_ch[1].acc == '0));
  assert_clamp_i_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($signed(drive_i) <= $signed({1'b0, $past(limit)}) &&
              $signed(drive_i) >= -$signed({1'b0, $past(limit)})));
  assert_clamp_q_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($signed(drive_q) <= $signed({1'b0, $past(limit)}) &&
              $signed(drive_q) >= -$signed({1'b0, $past(limit)})));
  assert_trig_restart_R2: assert property (@(posedge clk) disable iff (rst)
    trig |=> (idx == '0));
  assert_idx_park_R2: assert property (@(posedge clk) disable iff (rst)
    (idx == LAST && !trig) |=> (idx == LAST));
endmodule

// File: tb/sim_iq_pi_ctrl.sv
module sim_iq_pi_ctrl;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst = 1, trig = 0, rf_off = 0, wr_en = 0, wr_sel = 0;
  logic [15:0] meas_i = 0, meas_q = 0, kp = 0, ki = 0, wr_i = 0, wr_q = 0;
  logic [14:0] limit = 15'h7fff;
  logic [5:0]  ff_dly = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [15:0] drive_i, drive_q;

  int errors = 0, checks = 0;
  bit done = 0;

  int tsp [N][2];
  int tff [N][2];
  int m_idx, m_sp[2], m_ms[2], m_ff[2], m_sr[63][2], m_drv[2];
  longint m_acc[2];

  always #10 clk = ~clk;

  iq_pi_ctrl #(.TAB_AW(AW)) u0 (
    .clk(clk), .rst(rst), .trig(trig), .rf_off(rf_off),
    .meas_i(meas_i), .meas_q(meas_q), .kp(kp), .ki(ki), .limit(limit),
    .ff_dly(ff_dly), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_i(wr_i), .wr_q(wr_q), .drive_i(drive_i), .drive_q(drive_q));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int ms[2];
    ms[0] = $signed(meas_i);
    ms[1] = $signed(meas_q);
    for (int c = 0; c < 2; c++) begin
      longint err, a, t, lim, fv;
      err = longint'(m_sp[c]) - longint'(m_ms[c]);
      a = m_acc[c] + err * longint'(ki);
      if (a > (64'sd1 <<< 39) - 1) a = (64'sd1 <<< 39) - 1;
      if (a < -(64'sd1 <<< 39)) a = -(64'sd1 <<< 39);
      fv = (ff_dly == 0) ? m_ff[c] : m_sr[ff_dly-1][c];
      t = ((err * longint'(kp)) >>> 7) + (a >>> 18) + fv;
      lim = longint'(limit);
      if (t > lim) t = lim;
      if (t < -lim) t = -lim;
      if (rf_off) begin m_acc[c] = 0; m_drv[c] = 0; end
      else begin m_acc[c] = a; m_drv[c] = int'(t); end
    end
    for (int k = 62; k > 0; k--) m_sr[k] = m_sr[k-1];
    m_sr[0] = m_ff;
    m_sp = tsp[m_idx];
    m_ff = tff[m_idx];
    m_ms = ms;
    if (wr_en) begin
      if (wr_sel) begin tff[wr_addr][0] = $signed(wr_i); tff[wr_addr][1] = $signed(wr_q); end
      else        begin tsp[wr_addr][0] = $signed(wr_i); tsp[wr_addr][1] = $signed(wr_q); end
    end
    if (trig) m_idx = 0;
    else if (m_idx != N-1) m_idx++;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    #5;
    model_step();
    chk(tag, $signed(drive_i), m_drv[0]);
    chk(tag, $signed(drive_q), m_drv[1]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin tsp[k] = '{0, 0}; tff[k] = '{0, 0}; end
    m_idx = N-1; m_sp = '{0, 0}; m_ms = '{0, 0}; m_ff = '{0, 0}; m_drv = '{0, 0}; m_acc = '{0, 0};
    for (int k = 0; k < 63; k++) m_sr[k] = '{0, 0};
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset drive_i", $signed(drive_i), 0);
    chk("R1 reset drive_q", $signed(drive_q), 0);
    rst = 0;

    // R3: load both tables, unit proportional gain, no integral
    kp = 128; ki = 0;
    for (int k = 0; k < N; k++) begin
      wr_en = 1; wr_sel = 0; wr_addr = AW'(k);
      wr_i = 16'((k + 1) * 100); wr_q = 16'(-(k * 37) - 5);
      cyc("R3");
      wr_sel = 1; wr_i = 16'(k * 11 - 60); wr_q = 16'(300 - k * 13);
      cyc("R3");
    end
    wr_en = 0;
    // R1: without a trigger the parked last entry is used
    repeat (4) cyc("R1");
    // R2: walk from entry 0 and hold at the end
    trig = 1; cyc("R2"); trig = 0;
    repeat (N + 6) cyc("R2");
    // R10: single-sample measurement pulse
    meas_i = 16'(500); meas_q = 16'(-700); cyc("R10");
    meas_i = 0; meas_q = 0;
    repeat (4) cyc("R10");
    // R4: proportional sweep
    for (int n = 0; n < 400; n++) begin
      kp = 16'($urandom_range(0, 4000));
      meas_i = 16'($urandom_range(0, 65535)); meas_q = 16'($urandom_range(0, 65535));
      trig = (n % 23 == 0);
      cyc("R4");
    end
    trig = 0;
    // R5: integral sweep with small errors
    kp = 0;
    for (int n = 0; n < 400; n++) begin
      ki = 16'($urandom_range(0, 3000));
      meas_i = 16'($signed($urandom_range(0, 400)) - 200);
      meas_q = 16'($signed($urandom_range(0, 400)) - 200);
      trig = (n % 29 == 0);
      cyc("R5");
    end
    // R9: rf_off clears integrator and drive
    ki = 2000; kp = 300; trig = 0;
    for (int n = 0; n < 60; n++) begin
      rf_off = (n >= 20 && n < 30);
      cyc("R9");
    end
    rf_off = 0;
    // R7: feedforward delay sweep over every setting
    kp = 64; ki = 0; meas_i = 0; meas_q = 0;
    for (int d = 0; d < 64; d++) begin
      ff_dly = 6'(d);
      trig = 1; cyc("R7"); trig = 0;
      repeat (20) cyc("R7");
    end
    ff_dly = 0;
    // R8: small limits
    for (int n = 0; n < 300; n++) begin
      limit = 15'($urandom_range(0, 600));
      kp = 16'($urandom_range(0, 2000));
      meas_i = 16'($urandom_range(0, 65535)); meas_q = 16'($urandom_range(0, 65535));
      trig = (n % 19 == 0);
      cyc("R8");
    end
    trig = 0; limit = 15'h7fff;
    // R6: drive accumulator to its rail, then reverse the error
    kp = 0; ki = 16'hffff;
    wr_en = 1; wr_sel = 0; wr_addr = AW'(N-1); wr_i = 16'h7fff; wr_q = 16'h8000;
    cyc("R6"); wr_en = 0;
    repeat (N + 2) cyc("R6");
    meas_i = 16'h8000; meas_q = 16'h7fff;
    repeat (300) cyc("R6");
    meas_i = 16'h7fff; meas_q = 16'h8000;
    wr_en = 1; wr_addr = AW'(N-1); wr_i = 16'h8000; wr_q = 16'h7fff;
    cyc("R6"); wr_en = 0;
    repeat (300) cyc("R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule